// File: doc/BRIEF.md
# Two-Phase Test Response Checker

This block judges the response of a sequential circuit under test while a test session runs. A session begins with a start pulse. An initialization stretch of programmable length comes first. While it runs, the circuit's outputs depend on its unknown power-up state, so the checker ignores them. A test stretch follows. In each of its cycles, the observed output word is compared with one stored fault-free value.

The block fetches the stored values through a read port on an external expected-response memory. Each entry of that memory holds an expected word and a care bit. Entries whose care bit is clear are skipped. The first care entry that mismatches raises a sticky detect flag and latches its index. A done flag rises when the session ends, whether or not a fault was found. Generating the stimulus and filling the memory are done outside the block.

Top module: `resp_chk_top`

## Requirements
- R1: After reset, `detected_o`, `done_o` and `fail_idx_o` are all zero.
- R2: Observed words seen during the initialization stretch are never compared. A mismatch there does not set `detected_o`.
- R3: In the test stretch, if a vector's entry has care bit 1 and `obs_i` differs from `exp_data_i`, `detected_o` goes high one clock later.
- R4: A test vector whose entry has care bit 0 never causes detection, whatever `obs_i` holds.
- R5: `fail_idx_o` holds the test index of the first mismatching care vector, counted from 0 at the first test vector. Later mismatches in the same session leave it unchanged.
- R6: Once set, `detected_o` and `fail_idx_o` hold until the next start pulse. A start pulse clears `detected_o`, `done_o` and `fail_idx_o` on the following clock.
- R7: `done_o` rises one clock after the last test vector is compared, with or without a mismatch. It holds until the next start pulse.
- R8: With `init_len_i` = 0, the first vector after the start pulse is compared as test index 0.
- R9: During test vector j, `exp_addr_o` equals j. The memory read is combinational within the cycle.
- R10: The block captures `init_len_i` and `tvec_last_i` on the start pulse. Changing them later in the session has no effect. The session has `init_len_i` initialization vectors and `tvec_last_i`+1 test vectors. Vector k is the one presented in the k-th cycle after the start pulse, with k counted from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start pulse |
| init_len_i | input | INIT_W | Number of initialization vectors |
| tvec_last_i | input | IDX_W | Index of the last test vector |
| obs_i | input | DATA_W | Observed output word of the circuit under test |
| exp_addr_o | output | IDX_W | Expected-memory read address |
| exp_data_i | input | DATA_W | Expected word read from memory |
| exp_care_i | input | 1 | Care bit read from memory |
| detected_o | output | 1 | Sticky fault-detected flag |
| fail_idx_o | output | IDX_W | Index of the first failing test vector |
| done_o | output | 1 | Session complete |

## Verification
The assertions check the following on every cycle:
- `detected_o`, `fail_idx_o` and `done_o` stay stable between start pulses.
- A start pulse clears the done flag.
- Every rise of `detected_o` is preceded by a care entry whose expected word differed from the observed word.

Only the bench scenarios can show the rest:
- That initialization words are really masked.
- That the index reported is the first failing one rather than a later one.
- That done arrives in exactly the right cycle for each initialization length and test length.

The bench sweeps every combination of a range of initialization lengths, test lengths and fault positions. Garbage is always present during initialization and on don't-care entries.

// File: rtl/resp_chk_pkg.sv
package resp_chk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INIT = 2'd1,
    PH_TEST = 2'd2
  } phase_e;
endpackage

// File: rtl/rc_phase_seq.sv
module rc_phase_seq
  import resp_chk_pkg::*;
#(
  parameter int INIT_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [INIT_W-1:0] init_len_i,
  input  logic [IDX_W-1:0]  tvec_last_i,
  output logic [IDX_W-1:0]  vec_idx_o,
  output logic              cmp_en_o,
  output logic              last_o
);
  localparam int CNT_W = (INIT_W > IDX_W) ? INIT_W : IDX_W;

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [INIT_W-1:0] init_q;
  logic [IDX_W-1:0]  last_q;
  logic              init_end;
  logic              test_end;

  assign init_end = (cnt_q == CNT_W'(init_q) - CNT_W'(1));
  assign test_end = (cnt_q == CNT_W'(last_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      init_q  <= '0;
      last_q  <= '0;
    end else if (start_i) begin
      // session parameters are captured here only
      init_q  <= init_len_i;
      last_q  <= tvec_last_i;
      cnt_q   <= '0;
      phase_q <= (init_len_i == '0) ? PH_TEST : PH_INIT;
    end else begin
      unique case (phase_q)
        PH_INIT: begin
          if (init_end) begin
            phase_q <= PH_TEST;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_TEST: begin
          if (test_end) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign vec_idx_o = cnt_q[IDX_W-1:0];
  assign cmp_en_o  = (phase_q == PH_TEST);
  assign last_o    = (phase_q == PH_TEST) && test_end;
endmodule

// File: rtl/rc_cmp.sv
module rc_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              en_i,
  input  logic              care_i,
  input  logic [DATA_W-1:0] obs_i,
  input  logic [DATA_W-1:0] exp_i,
  output logic              miss_o
);
  logic [DATA_W-1:0] diff;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign diff[b] = obs_i[b] ^ exp_i[b];
  end

  assign miss_o = en_i && care_i && (|diff);
endmodule

// File: rtl/rc_result.sv
module rc_result #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             miss_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             detected_o,
  output logic [IDX_W-1:0] fail_idx_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      detected_o <= 1'b0;
      fail_idx_o <= '0;
      done_o     <= 1'b0;
    end else if (start_i) begin
      detected_o <= 1'b0;
      fail_idx_o <= '0;
      done_o     <= 1'b0;
    end else begin
      // first failure wins
      if (miss_i && !detected_o) begin
        detected_o <= 1'b1;
        fail_idx_o <= idx_i;
      end
      if (last_i) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/resp_chk_top.sv
module resp_chk_top #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int INIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [INIT_W-1:0] init_len_i,
  input  logic [IDX_W-1:0]  tvec_last_i,
  input  logic [DATA_W-1:0] obs_i,
  output logic [IDX_W-1:0]  exp_addr_o,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic              exp_care_i,
  output logic              detected_o,
  output logic [IDX_W-1:0]  fail_idx_o,
  output logic              done_o
);
  logic [IDX_W-1:0] vec_idx;
  logic             cmp_en;
  logic             last;
  logic             miss;

  rc_phase_seq #(.INIT_W(INIT_W), .IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .init_len_i  (init_len_i),
    .tvec_last_i (tvec_last_i),
    .vec_idx_o   (vec_idx),
    .cmp_en_o    (cmp_en),
    .last_o      (last)
  );

  rc_cmp #(.DATA_W(DATA_W)) u_cmp (
    .en_i   (cmp_en),
    .care_i (exp_care_i),
    .obs_i  (obs_i),
    .exp_i  (exp_data_i),
    .miss_o (miss)
  );

  rc_result #(.IDX_W(IDX_W)) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .miss_i     (miss),
    .last_i     (last),
    .idx_i      (vec_idx),
    .detected_o (detected_o),
    .fail_idx_o (fail_idx_o),
    .done_o     (done_o)
  );

  assign exp_addr_o = vec_idx;
endmodule

// File: rtl/rc_chk.sv
module rc_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] obs_i,
  input logic [DATA_W-1:0] exp_data_i,
  input logic              exp_care_i,
  input logic              detected_o,
  input logic [IDX_W-1:0]  fail_idx_o,
  input logic              done_o
);
  AST_DET_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detected_o && !start_i) |=> detected_o); // R6

  AST_IDX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detected_o && !start_i) |=> $stable(fail_idx_o)); // R5

  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R7

  AST_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !detected_o)); // R6

  AST_DET_CARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detected_o) |-> $past(exp_care_i)); // R4

  AST_DET_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detected_o) |-> $past(obs_i != exp_data_i)); // R3
endmodule

bind resp_chk_top rc_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_resp_chk_top.sv
module sim_resp_chk_top;
  localparam int DW = 4;
  localparam int IW = 3;
  localparam int NW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [NW-1:0] init_len_i = '0;
  logic [IW-1:0] tvec_last_i = '0;
  logic [DW-1:0] obs_i = '0;
  logic [IW-1:0] exp_addr_o;
  logic [DW-1:0] exp_data_i;
  logic          exp_care_i;
  logic          detected_o;
  logic [IW-1:0] fail_idx_o;
  logic          done_o;

  logic [DW-1:0] exp_mem [8];
  logic          care_mem [8];
  logic [DW-1:0] seq [16];

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  assign exp_data_i = exp_mem[exp_addr_o];
  assign exp_care_i = care_mem[exp_addr_o];

  resp_chk_top #(.DATA_W(DW), .IDX_W(IW), .INIT_W(NW)) u0 (.*);

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // one session: L init vectors, test indices 0..T, care fault at ep (-1 none)
  task automatic run(int L, int T, int ep);
    int det = 0;
    int fi = 0;
    string dreq;
    for (int j = 0; j < 8; j++) begin
      exp_mem[j]  = DW'((j * 5 + L + 3) & 15);
      care_mem[j] = (j % 3) != 2;
    end
    for (int k = 0; k < L; k++) seq[k] = ~exp_mem[k % 8];
    for (int j = 0; j <= T; j++) begin
      if (!care_mem[j]) seq[L+j] = exp_mem[j] ^ 4'h6;
      else if (j == ep || (ep >= 0 && ep < j && j == T)) seq[L+j] = exp_mem[j] ^ 4'h9;
      else seq[L+j] = exp_mem[j];
    end
    for (int j = 0; j <= T; j++)
      if (det == 0 && care_mem[j] && seq[L+j] != exp_mem[j]) begin
        det = 1;
        fi = j;
      end
    dreq = (L == 0) ? "R8" : ((ep < 0) ? "R2" : ((ep <= T && !care_mem[ep]) ? "R4" : "R3"));

    @(negedge clk_i);
    start_i = 1'b1;
    init_len_i = NW'(L);
    tvec_last_i = IW'(T);
    @(negedge clk_i);
    start_i = 1'b0;
    init_len_i = ~NW'(L);   // R10: later changes must not matter
    tvec_last_i = ~IW'(T);
    check("R6 clear det", int'(detected_o), 0);
    check("R6 clear done", int'(done_o), 0);
    for (int k = 0; k <= L + T; k++) begin
      if (k > 0) @(negedge clk_i);
      obs_i = seq[k];
      if (k == L) check("R9 addr", int'(exp_addr_o), 0);
      if (k == L + T) check("R7 done early R10", int'(done_o), 0);
    end
    @(negedge clk_i);
    obs_i = 4'hF;
    check(dreq, int'(detected_o), det);
    if (det != 0) check("R5 fail_idx", int'(fail_idx_o), fi);
    check("R7 done R10", int'(done_o), 1);
    @(negedge clk_i);
    obs_i = 4'h0;
    @(negedge clk_i);
    check("R6 det held", int'(detected_o), det);
    if (det != 0) check("R6 idx held", int'(fail_idx_o), fi);
    check("R7 done held", int'(done_o), 1);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 8; j++) begin
      exp_mem[j] = '0;
      care_mem[j] = 1'b0;
    end
    #35;
    check("R1 det", int'(detected_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 idx", int'(fail_idx_o), 0);
    rst_ni = 1'b1;
    for (int L = 0; L <= 4; L++)
      for (int T = 0; T <= 5; T++)
        for (int ep = -1; ep <= T; ep++)
          run(L, T, ep);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule